// File: doc/BRIEF.md
# Prescaled PWM Channel Generator

This block produces one pulse-width-modulated output, such as an LED drive line. A small byte-wide register port sets the period and the duty. The count tick comes from one of several reference-clock enables, picked by a select field. That tick is divided by a non-power-of-two pre-divider (1, 3, 5 or 6) and then by a power-of-two exponent stage (2^0 to 2^7). It then steps a counter whose width, 8 to 15 bits, comes from a resolution field. The output is high while the counter is below the compare value.

The compare value comes either from the programmed 16-bit duty register or from an external ramp input, chosen by the control register. The control register also holds the channel enable and the output-driver enable. When the glitch-free update option is set, period and duty changes are held in shadow registers. They reach the counter only when the period wraps or when a sync strobe is written. Reference oscillators and analog drivers are outside this block; the oscillators arrive as one-cycle tick enables.

Top module: `pwm_chan_gen`

## Requirements
- R1: After synchronous reset, pwm_out and pwm_oe are 0 and every register reads back 0.
- R2: The output period is 2^(8+S) × D × 2^E selected reference ticks. S is the resolution field at bits [6:4] of the size/clock register (address 0).
- R3: The pre-divider field at bits [6:5] of the divider register (address 1) encodes 0,1,2,3 as divide ratios 1,3,5,6. The exponent E sits at bits [2:0] of that register.
- R4: Clock select at bits [2:0] of address 0: a value k in 1..NUM_REF takes ref_tick[k-1]. A value of 0 or above NUM_REF stops the count, and pwm_out stays 0.
- R5: The 16-bit duty value is written as a low byte (address 2) and a high byte (address 3). Over each period, pwm_out is high for the first duty counter states.
- R6: A compare value of 2^(8+S)−1 or more makes pwm_out high for the whole period.
- R7: Control register (address 4) bit 7 enables the channel. While it is clear, pwm_out is 0 and the dividers and counter restart from zero.
- R8: Control bit 5 drives pwm_oe, registered.
- R9: Control bit 1 takes the compare value from ramp_duty. Otherwise control bit 2 takes it from the duty register. With neither bit set, the compare value is 0 and the output stays low.
- R10: With bit 5 of the update register (address 5) set and the channel enabled, new select, size, divider and duty values take effect only at a period wrap. Otherwise they take effect on the cycle after the write.
- R11: Writing 1 to bit 0 of the sync address (address 6) loads the pending settings at once, even mid-period.
- R12: Addresses 0 to 5 read back the last byte written. A read returns its data one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| ref_tick | input | NUM_REF | Reference-clock tick enables |
| ramp_duty | input | 16 | External ramp compare value |
| pwm_out | output | 1 | PWM output |
| pwm_oe | output | 1 | Output driver enable |

## Verification
A write lands in its register at the next edge. With the glitch-free option off, the active copy follows one edge later, and the output register adds one more edge. A read returns its data one edge after rd_en. The duty and period checks wait one full period after enabling, then count high samples over exactly one period or time rise-to-rise intervals. Those measurements do not depend on the pipeline phase. For the glitch-free and sync cases, the window starts on an observed rising edge, so the point where a write lands is known relative to the counter. All samples are taken on the falling clock edge.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;
  localparam int DATA_W    = 8;
  localparam int DUTY_W    = 16;
  localparam int MIN_RES   = 8;
  localparam int SEL_W     = 3;
  localparam int MAX_RES   = MIN_RES + (1 << SEL_W) - 1;
  localparam int EXPCNT_W  = (1 << SEL_W) - 1;

  localparam int REG_SIZECLK = 0;
  localparam int REG_DIVCFG  = 1;
  localparam int REG_DUTY_LO = 2;
  localparam int REG_DUTY_HI = 3;
  localparam int REG_CTL     = 4;
  localparam int REG_UPD     = 5;
  localparam int REG_SYNC    = 6;

  typedef struct packed {
    logic [SEL_W-1:0]  clk_sel;
    logic [SEL_W-1:0]  res_sel;
    logic [1:0]        pdiv_sel;
    logic [SEL_W-1:0]  expo;
    logic [DUTY_W-1:0] duty;
  } pwm_cfg_t;

  function automatic logic [2:0] pdiv_ratio(input logic [1:0] s);
    case (s)
      2'd0:    return 3'd1;
      2'd1:    return 3'd3;
      2'd2:    return 3'd5;
      default: return 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/pwmch_regs.sv
module pwmch_regs
  import pwmch_pkg::*;
#(
  parameter int HI_RES = 1,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              wrap,
  output pwm_cfg_t          act,
  output logic              ctl_en,
  output logic              ctl_oe,
  output logic              src_ramp,
  output logic              src_pwm
);
  logic [DATA_W-1:0] sizeclk_q, divcfg_q, duty_lo_q, duty_hi_q, ctl_q, upd_q;
  logic [SEL_W-1:0]  shd_clk, shd_res;
  pwm_cfg_t          shd;
  logic              sync_stb, load;

  // variant: wide select and selectable size, or narrow select and fixed 9-bit size
  generate
    if (HI_RES != 0) begin : g_hires
      assign shd_clk = sizeclk_q[2:0];
      assign shd_res = sizeclk_q[6:4];
    end else begin : g_std
      assign shd_clk = {1'b0, sizeclk_q[1:0]};
      assign shd_res = SEL_W'(1);
    end
  endgenerate

  always_comb begin
    shd.clk_sel  = shd_clk;
    shd.res_sel  = shd_res;
    shd.pdiv_sel = divcfg_q[6:5];
    shd.expo     = divcfg_q[2:0];
    shd.duty     = {duty_hi_q, duty_lo_q};
  end

  assign sync_stb = wr_en && (addr == ADDR_W'(REG_SYNC)) && wdata[0];
  assign load     = !upd_q[5] || !ctl_q[7] || sync_stb || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sizeclk_q <= '0;
      divcfg_q  <= '0;
      duty_lo_q <= '0;
      duty_hi_q <= '0;
      ctl_q     <= '0;
      upd_q     <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(REG_SIZECLK): sizeclk_q <= wdata;
        ADDR_W'(REG_DIVCFG):  divcfg_q  <= wdata;
        ADDR_W'(REG_DUTY_LO): duty_lo_q <= wdata;
        ADDR_W'(REG_DUTY_HI): duty_hi_q <= wdata;
        ADDR_W'(REG_CTL):     ctl_q     <= wdata;
        ADDR_W'(REG_UPD):     upd_q     <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       act <= '0;
    else if (load) act <= shd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        ADDR_W'(REG_SIZECLK): rdata <= sizeclk_q;
        ADDR_W'(REG_DIVCFG):  rdata <= divcfg_q;
        ADDR_W'(REG_DUTY_LO): rdata <= duty_lo_q;
        ADDR_W'(REG_DUTY_HI): rdata <= duty_hi_q;
        ADDR_W'(REG_CTL):     rdata <= ctl_q;
        ADDR_W'(REG_UPD):     rdata <= upd_q;
        default:              rdata <= '0;
      endcase
    end
  end

  assign ctl_en   = ctl_q[7];
  assign ctl_oe   = ctl_q[5];
  assign src_pwm  = ctl_q[2];
  assign src_ramp = ctl_q[1];
endmodule

// File: rtl/pwmch_tickdiv.sv
module pwmch_tickdiv
  import pwmch_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sel_tick,
  input  logic [1:0]       pdiv_sel,
  input  logic [SEL_W-1:0] expo,
  output logic             cnt_tick
);
  logic [2:0]          pd_cnt, ratio;
  logic [EXPCNT_W-1:0] ex_cnt, ex_mask;
  logic                pre_last, pre_tick;

  assign ratio    = pdiv_ratio(pdiv_sel);
  assign pre_last = pd_cnt >= (ratio - 3'd1);
  assign pre_tick = sel_tick && pre_last;
  assign ex_mask  = EXPCNT_W'((9'd1 << expo) - 9'd1);
  assign cnt_tick = pre_tick && ((ex_cnt & ex_mask) == ex_mask);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pd_cnt <= '0;
      ex_cnt <= '0;
    end else begin
      if (sel_tick) pd_cnt <= pre_last ? 3'd0 : pd_cnt + 3'd1;
      if (pre_tick) ex_cnt <= cnt_tick ? '0 : ex_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwmch_counter.sv
module pwmch_counter
  import pwmch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cnt_tick,
  input  logic [SEL_W-1:0]  res_sel,
  input  logic [DUTY_W-1:0] cmp,
  output logic              wrap,
  output logic              pwm_q
);
  logic [MAX_RES-1:0] cnt, cnt_max;
  logic               full;

  assign cnt_max = MAX_RES'((32'd1 << (32'(MIN_RES) + 32'(res_sel))) - 32'd1);
  assign wrap    = cnt_tick && (cnt >= cnt_max);
  assign full    = cmp >= DUTY_W'(cnt_max);

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (wrap)     cnt <= '0;
    else if (cnt_tick) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= run && (full || (DUTY_W'(cnt) < cmp));
  end
endmodule

// File: rtl/pwm_chan_gen.sv
module pwm_chan_gen
  import pwmch_pkg::*;
#(
  parameter int HI_RES  = 1,
  parameter int NUM_REF = 4,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_REF-1:0] ref_tick,
  input  logic [DUTY_W-1:0]  ramp_duty,
  output logic               pwm_out,
  output logic               pwm_oe
);
  pwm_cfg_t          act;
  logic              ctl_en, ctl_oe, src_ramp, src_pwm;
  logic              clk_ok, run, sel_tick, cnt_tick, wrap;
  logic [DUTY_W-1:0] cmp;

  pwmch_regs #(.HI_RES(HI_RES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wrap(wrap), .act(act),
    .ctl_en(ctl_en), .ctl_oe(ctl_oe), .src_ramp(src_ramp), .src_pwm(src_pwm)
  );

  always_comb begin
    sel_tick = 1'b0;
    clk_ok   = 1'b0;
    for (int i = 0; i < NUM_REF; i++) begin
      if (32'(act.clk_sel) == i + 1) begin
        sel_tick = ref_tick[i];
        clk_ok   = 1'b1;
      end
    end
  end

  assign run = ctl_en && clk_ok;
  assign cmp = src_ramp ? ramp_duty : (src_pwm ? act.duty : '0);

  pwmch_tickdiv u_div (
    .clk(clk), .rst(rst), .run(run), .sel_tick(sel_tick),
    .pdiv_sel(act.pdiv_sel), .expo(act.expo), .cnt_tick(cnt_tick)
  );

  pwmch_counter u_cnt (
    .clk(clk), .rst(rst), .run(run), .cnt_tick(cnt_tick),
    .res_sel(act.res_sel), .cmp(cmp), .wrap(wrap), .pwm_q(pwm_out)
  );

  always_ff @(posedge clk) begin
    if (rst) pwm_oe <= 1'b0;
    else     pwm_oe <= ctl_oe;
  end
endmodule

// File: rtl/pwmch_chk.sv
module pwmch_chk
  import pwmch_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              ctl_en,
  input logic              ctl_oe,
  input logic              clk_ok,
  input logic              run,
  input logic              wrap,
  input logic [DUTY_W-1:0] cmp,
  input pwm_cfg_t          act,
  input logic              pwm_out,
  input logic              pwm_oe
);
  logic upd_on, sync_w;
  logic [DUTY_W-1:0] full_thr;

  always_ff @(posedge clk) begin
    if (rst) upd_on <= 1'b0;
    else if (wr_en && addr == ADDR_W'(REG_UPD)) upd_on <= wdata[5];
  end

  assign sync_w   = wr_en && addr == ADDR_W'(REG_SYNC) && wdata[0];
  assign full_thr = DUTY_W'((32'd1 << (32'(MIN_RES) + 32'(act.res_sel))) - 32'd1);

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |=> !pwm_out); // R7
  AST_NOCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !clk_ok |=> !pwm_out); // R4
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (run && cmp >= full_thr) |=> pwm_out); // R6
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
    (cmp == '0) |=> !pwm_out); // R5
  AST_OE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    $past(ctl_oe) == pwm_oe || $rose(rst) || $fell(rst)); // R8
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (rst)
    (upd_on && ctl_en && !sync_w && !wrap) |=> $stable(act)); // R10
endmodule

bind pwm_chan_gen pwmch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ctl_en(ctl_en), .ctl_oe(ctl_oe), .clk_ok(clk_ok), .run(run), .wrap(wrap),
  .cmp(cmp), .act(act), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
);

// File: tb/tb_pwm_chan_gen.sv
module tb_pwm_chan_gen;
  localparam int ADDR_W  = 3;
  localparam int NUM_REF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NUM_REF-1:0] ref_tick = '0;
  logic [15:0] ramp_duty = '0;
  logic pwm_out, pwm_oe;
  logic ph = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pwm_chan_gen #(.HI_RES(1), .NUM_REF(NUM_REF), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ref_tick(ref_tick), .ramp_duty(ramp_duty),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  // ref_tick[0] every cycle, ref_tick[1] every second cycle
  always @(negedge clk) begin
    ph <= ~ph;
    ref_tick <= {2'b00, ph, 1'b1};
  end

  typedef struct packed {
    logic [2:0]  sel;
    logic [2:0]  res;
    logic [1:0]  pd;
    logic [2:0]  ex;
    logic [15:0] duty;
    logic        use_ramp;
    logic [15:0] ramp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 3'd0, 2'd0, 3'd0, 16'd100,  1'b0, 16'd0},
    '{3'd1, 3'd0, 2'd1, 3'd1, 16'd37,   1'b0, 16'd0},
    '{3'd1, 3'd1, 2'd2, 3'd0, 16'd300,  1'b0, 16'd0},
    '{3'd2, 3'd0, 2'd0, 3'd2, 16'd64,   1'b0, 16'd0},
    '{3'd1, 3'd0, 2'd3, 3'd0, 16'd255,  1'b0, 16'd0},
    '{3'd1, 3'd0, 2'd0, 3'd0, 16'd0,    1'b0, 16'd0},
    '{3'd1, 3'd0, 2'd0, 3'd1, 16'd1000, 1'b0, 16'd0},
    '{3'd1, 3'd0, 2'd0, 3'd0, 16'd254,  1'b1, 16'd90},
    '{3'd1, 3'd2, 2'd0, 3'd1, 16'd5,    1'b0, 16'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rdata);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  task automatic wait_rise();
    logic last = pwm_out;
    for (int g = 0; g < 40000; g++) begin
      @(negedge clk);
      if (pwm_out && !last) return;
      last = pwm_out;
    end
  endtask

  task automatic rise_interval(output int n);
    logic last = 1'b1;
    wait_rise();
    n = 0;
    for (int g = 0; g < 40000; g++) begin
      @(negedge clk);
      n++;
      if (pwm_out && !last) return;
      last = pwm_out;
    end
  endtask

  function automatic int ratio_of(input logic [1:0] pd);
    case (pd)
      2'd0: return 1;
      2'd1: return 3;
      2'd2: return 5;
      default: return 6;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d, h, n, p, full_n, cmpv, eff, step;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(pwm_out == 1'b0, "R1 pwm_out after reset", int'(pwm_out), 0);
    check(pwm_oe == 1'b0, "R1 pwm_oe after reset", int'(pwm_oe), 0);
    rd(2, d); check(d == 0, "R1 duty_lo after reset", d, 0);
    rd(4, d); check(d == 0, "R1 ctl after reset", d, 0);

    // R12 readback
    wr(3, 8'hA5); rd(3, d); check(d == 'hA5, "R12 duty_hi readback", d, 'hA5);
    wr(0, 8'h5B); rd(0, d); check(d == 'h5B, "R12 sizeclk readback", d, 'h5B);
    wr(5, 8'h3C); rd(5, d); check(d == 'h3C, "R12 update reg readback", d, 'h3C);
    wr(5, 0); wr(3, 0);

    // vector table: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      wr(4, 0);
      wr(0, {1'b0, VEC[v].res, 1'b0, VEC[v].sel});
      wr(1, {1'b0, VEC[v].pd, 2'b00, VEC[v].ex});
      wr(2, VEC[v].duty[7:0]);
      wr(3, VEC[v].duty[15:8]);
      ramp_duty = VEC[v].ramp;
      wr(4, VEC[v].use_ramp ? 8'hA2 : 8'hA4);
      full_n = 1 << (8 + VEC[v].res);
      step = ratio_of(VEC[v].pd) * (1 << VEC[v].ex) * (VEC[v].sel == 3'd2 ? 2 : 1);
      p = full_n * step;
      cmpv = VEC[v].use_ramp ? int'(VEC[v].ramp) : int'(VEC[v].duty);
      eff = (cmpv >= full_n - 1) ? full_n : cmpv;
      repeat (p) @(negedge clk);
      count_high(p, h);
      check(h == eff * step, $sformatf("R5 R6 R9 high count vec %0d", v), h, eff * step);
      if (eff > 0 && eff < full_n) begin
        rise_interval(n);
        check(n == p, $sformatf("R2 R3 R4 period vec %0d", v), n, p);
      end
    end
    ramp_duty = '0;

    // R7 disabled: oe on, enable off
    wr(4, 0);
    wr(0, 8'h01); wr(1, 0); wr(2, 100); wr(3, 0);
    wr(4, 8'h24);
    count_high(512, h); check(h == 0, "R7 disabled output low", h, 0);
    check(pwm_oe == 1'b1, "R8 oe set", int'(pwm_oe), 1);
    wr(4, 8'h04); @(negedge clk);
    check(pwm_oe == 1'b0, "R8 oe cleared", int'(pwm_oe), 0);

    // R4 no clock and out-of-range select
    wr(0, 8'h00); wr(4, 8'hA4);
    count_high(512, h); check(h == 0, "R4 select 0 output low", h, 0);
    wr(0, 8'h05);
    count_high(512, h); check(h == 0, "R4 select above range low", h, 0);

    // R9 no source selected
    wr(0, 8'h01); wr(4, 8'h80);
    count_high(512, h); check(h == 0, "R9 no source output low", h, 0);

    // R10 glitch-free update: mid-period duty write held until wrap
    wr(4, 8'hA4); wr(5, 8'h20);
    repeat (300) @(negedge clk);
    wait_rise();
    fork
      count_high(256, h);
      begin repeat (20) @(negedge clk); wr(2, 10); end
    join
    check(h == 100, "R10 old duty held this period", h, 100);
    count_high(256, h);
    check(h == 10, "R10 new duty after wrap", h, 10);

    // R11 sync strobe applies mid-period
    wait_rise();
    fork
      count_high(256, h);
      begin repeat (30) @(negedge clk); wr(2, 200); wr(6, 1); end
    join
    check(h > 100, "R11 sync applies at once", h, 150);
    count_high(256, h);
    check(h == 200, "R11 synced duty steady", h, 200);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule